// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block sits between an on-chip requester and an external asynchronous static RAM of 128K bytes. The requester offers one byte-wide read or write at a time over a valid/ready handshake. The controller turns each request into a timed series of chip-enable, output-enable and write-enable levels, holds the address steady for the whole selected interval, and controls the direction of the shared data bus. It captures read data and returns it with a one-cycle valid pulse.

The sequencing is a Moore state machine with six states. `ST_IDLE` deselects the memory and accepts a request. `ST_RD_ACCESS` holds the output enable low for the read access time. `ST_TURN` is the bus turnaround gap, used only when a write follows a read. `ST_WR_SETUP` presents address and data with the write strobe still high. `ST_WR_PULSE` holds the write strobe low. `ST_WR_HOLD` keeps the data driven for one cycle after the write strobe rises.

The transitions are as follows. From `ST_IDLE`, a read request goes to `ST_RD_ACCESS`. A write request goes to `ST_TURN` if the previous access was a read, and to `ST_WR_SETUP` otherwise. `ST_RD_ACCESS` returns to `ST_IDLE` when its timer expires. `ST_TURN` moves to `ST_WR_SETUP` when its timer expires. `ST_WR_SETUP` always moves to `ST_WR_PULSE`. `ST_WR_PULSE` moves to `ST_WR_HOLD` when its timer expires. `ST_WR_HOLD` always returns to `ST_IDLE`. Three parameters set the number of clock cycles for the read access, the write pulse and the turnaround, and each must be at least 1.

Top module: `sram_port_ctrl`

## Requirements
- R1: While the synchronous active-high reset is held, and on the first cycle after it, `mem_ce1_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `req_ready`=1 and `rd_valid`=0.
- R2: With no request in progress, the memory is deselected: `mem_ce1_n`=1 and `mem_ce2`=0.
- R3: `req_ready` is high only in the idle state. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` then stays low for exactly as many cycles as the access sequence lasts.
- R4: A read selects the memory (`mem_ce1_n`=0, `mem_ce2`=1), holds `mem_oe_n` low and `mem_we_n` high for RD_CYC consecutive cycles, and never drives the data bus.
- R5: Read data is sampled from `mem_dq_i` on the last output-enable-low cycle. It appears on `rd_data` in the next cycle, together with a `rd_valid` pulse that is exactly one cycle long.
- R6: A write selects the memory and keeps `mem_oe_n` high throughout. It presents address and data for one cycle with `mem_we_n` high, and then holds `mem_we_n` low for WR_CYC consecutive cycles.
- R7: `mem_dq_oe` is high on the cycle in which `mem_we_n` falls. It is still high on the cycle after `mem_we_n` rises, and low on the cycle after that.
- R8: `mem_addr` does not change while the memory stays selected from one cycle to the next.
- R9: A write accepted directly after a read first spends TURN_CYC cycles selected with `mem_oe_n` high, `mem_we_n` high and the bus undriven. The bus is never driven while `mem_oe_n` is low.
- R10: A write that does not follow a read skips the turnaround. It is busy for WR_CYC+2 cycles, while a write after a read is busy for TURN_CYC+WR_CYC+2 cycles and a read for RD_CYC cycles.
- R11: A byte written at any 17-bit address, including 0 and 0x1FFFF, is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request taken this edge if valid |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| mem_addr | output | 17 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | 8 | Data driven to the memory |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_i | input | 8 | Data returned from the memory |

## Verification
The bench attaches a behavioural memory that latches a byte on each rising write strobe. It runs several request patterns:
- back-to-back writes, which must never insert a turnaround;
- a write right after a read, which must insert exactly TURN_CYC extra busy cycles;
- repeated reads, which show that read-after-read needs no gap;
- a write followed at once by a read of the same address, which shows that the commit happens on the rising strobe.

The addresses 0 and 0x1FFFF check that the address bits reach the memory at their correct positions. The strobe pulse lengths and the bus drive window are measured on every access.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctrl_state_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // After a load of a non-zero value the timer is not yet expired.
    p_load_not_expired_r10: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= dq_i;
            end
        end
    end

    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int RD_CYC   = 2,
    parameter int WR_CYC   = 2,
    parameter int TURN_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int MAX_AB  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int MAX_CYC = (MAX_AB > TURN_CYC) ? MAX_AB : TURN_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctrl_state_e       state_q, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              after_read_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              accept;
    logic              capture;
    strobe_t           strb;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign capture = (state_q == ST_RD_ACCESS) && tmr_expired;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Request latch and read-history flag
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q       <= '0;
            wdata_q      <= '0;
            after_read_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                if (req_write) begin
                    after_read_q <= 1'b0;
                end
            end
            if (capture) begin
                after_read_q <= 1'b1;
            end
        end
    end

    // Next state and timer loads
    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write) begin
                        state_nx = ST_RD_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_CYC - 1);
                    end else if (after_read_q) begin
                        state_nx = ST_TURN;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(TURN_CYC - 1);
                    end else begin
                        state_nx = ST_WR_SETUP;
                    end
                end
            end
            ST_RD_ACCESS: if (tmr_expired) state_nx = ST_IDLE;
            ST_TURN:      if (tmr_expired) state_nx = ST_WR_SETUP;
            ST_WR_SETUP: begin
                state_nx = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WR_CYC - 1);
            end
            ST_WR_PULSE:  if (tmr_expired) state_nx = ST_WR_HOLD;
            ST_WR_HOLD:   state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        strb = '{ce1_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        unique case (state_q)
            ST_IDLE:      strb = '{ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
            ST_RD_ACCESS: strb.oe_n  = 1'b0;
            ST_TURN:      strb.drive = 1'b0;
            ST_WR_SETUP:  strb.drive = 1'b1;
            ST_WR_PULSE: begin
                strb.we_n  = 1'b0;
                strb.drive = 1'b1;
            end
            ST_WR_HOLD:   strb.drive = 1'b1;
            default:      strb = '{ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        endcase
    end

    assign mem_ce1_n = strb.ce1_n;
    assign mem_ce2   = strb.ce2;
    assign mem_oe_n  = strb.oe_n;
    assign mem_we_n  = strb.we_n;
    assign mem_dq_oe = strb.drive;
    assign mem_addr  = addr_q;
    assign mem_dq_o  = wdata_q;
    assign req_ready = (state_q == ST_IDLE);

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .dq_i     (mem_dq_i),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));
    p_no_drive_oe_r9: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);
    p_we_after_setup_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> ($past(!mem_ce1_n) && $past(mem_dq_oe) && mem_oe_n));
    p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_dq_oe);
    p_busy_not_ready_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_ce1_n |-> !req_ready);
    p_idle_deselect_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce1_n && !mem_ce2));
    p_read_no_drive_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe && mem_ce2));
endmodule

// File: tb/sram_port_ctrl_bench.sv
module sram_port_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int RDC = 3;
    localparam int WRC = 2;
    localparam int TNC = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o, mem_dq_i;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [DW-1:0] sram [int];
    logic [DW-1:0] shadow [int];
    logic [DW-1:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_port_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RDC), .WR_CYC(WRC), .TURN_CYC(TNC))
    u_sram_port_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    // Behavioural memory: commits on the rising write strobe
    always @(posedge mem_we_n) begin
        if (mem_ce1_n === 1'b0 && mem_ce2 === 1'b1 && mem_dq_oe === 1'b1)
            sram[int'(mem_addr)] = mem_dq_o;
    end

    function automatic logic [DW-1:0] mem_read(input logic [AW-1:0] a, input logic sel);
        if (!sel) return 8'hEE;
        if (sram.exists(int'(a))) return sram[int'(a)];
        return 8'h5A;
    endfunction

    assign mem_dq_i = mem_read(mem_addr, !mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard pop and strobe measurements
    int we_run = 0;
    int oe_run = 0;
    bit hold_pending = 1'b0;
    int viol_r8 = 0;
    int viol_r9 = 0;
    int viol_r4 = 0;
    logic          prev_sel = 1'b0;
    logic [AW-1:0] prev_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) chk("R5 unexpected rd_valid", 1, 0);
                else chk("R5 read data", {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
            end
            if (hold_pending) begin
                chk("R7 driver released after hold", {31'h0, mem_dq_oe}, 0);
                hold_pending = 1'b0;
            end
            if (!mem_we_n) begin
                if (we_run == 0) chk("R7 driving at WE fall", {31'h0, mem_dq_oe}, 1);
                we_run++;
                if (!mem_oe_n) viol_r9++;
            end else if (we_run != 0) begin
                chk("R6 WE low length", we_run, WRC);
                chk("R7 data held after WE rise", {31'h0, mem_dq_oe}, 1);
                hold_pending = 1'b1;
                we_run = 0;
            end
            if (!mem_oe_n) begin
                oe_run++;
                if (mem_dq_oe || mem_ce1_n || !mem_ce2) viol_r4++;
            end else if (oe_run != 0) begin
                chk("R4 OE low length", oe_run, RDC);
                oe_run = 0;
            end
            if (mem_dq_oe && !mem_oe_n) viol_r9++;
            if (!mem_ce1_n && prev_sel && mem_addr !== prev_addr) viol_r8++;
            prev_sel  = !mem_ce1_n;
            prev_addr = mem_addr;
        end
    end

    // Driver: issue one request and measure the busy span (R3, R10, R9)
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int exp_busy, input string req);
        int busy = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (!wr) exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h5A);
        else shadow[int'(a)] = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) begin
            busy++;
            @(negedge clk);
        end
        chk(req, busy, exp_busy);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 ce1_n", {31'h0, mem_ce1_n}, 1);
        chk("R1 ce2", {31'h0, mem_ce2}, 0);
        chk("R1 oe_n/we_n", {30'h0, mem_oe_n, mem_we_n}, 3);
        chk("R1 dq_oe", {31'h0, mem_dq_oe}, 0);
        chk("R1 ready/rd_valid", {30'h0, req_ready, rd_valid}, 2);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle after reset", {27'h0, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, req_ready}, 5'b10111);
        // Back-to-back writes: no turnaround (R10)
        issue(1, 17'h00000, 8'h11, WRC + 2, "R10 write busy");
        issue(1, 17'h1FFFF, 8'hC3, WRC + 2, "R10 write after write busy");
        issue(1, 17'h0A5A5, 8'h7E, WRC + 2, "R10 third write busy");
        // Reads back to back (R4, R11)
        issue(0, 17'h00000, 8'h00, RDC, "R3 read busy");
        issue(0, 17'h1FFFF, 8'h00, RDC, "R11 read busy top address");
        // Write after read: turnaround (R9)
        issue(1, 17'h00001, 8'h96, TNC + WRC + 2, "R9 write after read busy");
        issue(1, 17'h00000, 8'hF0, WRC + 2, "R10 overwrite busy");
        issue(0, 17'h00000, 8'h00, RDC, "R11 read overwritten");
        issue(0, 17'h00001, 8'h00, RDC, "R11 read after turnaround write");
        issue(0, 17'h12345, 8'h00, RDC, "R11 read unwritten");
        issue(0, 17'h0A5A5, 8'h00, RDC, "R11 read mid address");
        // Idle gap (R2)
        repeat (4) @(negedge clk);
        chk("R2 idle deselect", {30'h0, mem_ce1_n, mem_ce2}, 2);
        chk("R3 ready in idle", {31'h0, req_ready}, 1);
        chk("R5 scoreboard drained", exp_q.size(), 0);
        chk("R8 address stable while selected", viol_r8, 0);
        chk("R9 no drive with OE low", viol_r9, 0);
        chk("R4 read strobes clean", viol_r4, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule